// File: doc/BRIEF.md
# Memory Test Address Sequencer

This block produces the run of logical DRAM addresses that a built-in memory self-test visits in one pass. A pass is defined by three things: a start address, an end address and a direction (up or down). Each address is packed into a 32-bit configuration word. A one-cycle start pulse loads the pass. After that, the block offers one row/column/bank address per burst access to the command engine, which accepts each address by raising `advance`. The column changes fastest, the bank next and the row slowest.

The column counter steps by whole bursts. The low column bits are implied zero and are never stored. Column bit 10 is the auto-precharge position, so the counter's carry passes over it and the block always drives it low. The burst-length select captured at start sets how the 12 stored column bits spread across the 16-bit column output. The rank is not part of the address, so a pass never changes it. When the end address has been accepted, the block drops its valid output and raises `done`.

Top module: `mtest_addr_seq`

## Requirements
- R1: While reset is asserted and after its release, `addr_valid` and `done` are 0 until a start pulse arrives.
- R2: A start pulse loads the counters. On the next cycle `addr_valid` is 1, `done` is 0, and the outputs carry the start address. The configuration word is laid out as row = bits 31:16, reserved = bit 15, column field = bits 14:3, bank = bits 2:0.
- R3: Each accepted address (`addr_valid` and `advance` both 1) steps the column by one burst. That is +4 on `col_addr` with 4-beat bursts (`burst8`=0) and +8 with 8-beat bursts (`burst8`=1). Row and bank stay unchanged unless the column wraps.
- R4: `col_addr` bit 10 is always 0, and so are its bits below the burst size. In 4-beat mode column field bits 11:8 drive `col_addr[14:11]` and bits 7:0 drive `col_addr[9:2]`. In 8-beat mode field bits 11:7 drive `col_addr[15:11]` and bits 6:0 drive `col_addr[9:3]`. The column after 0x3FC (4-beat) or 0x3F8 (8-beat) is 0x800.
- R5: In up mode, a column field wrapping from all ones to zero increments the bank. A bank wrapping from 7 to 0 also increments the row.
- R6: In down mode all counters decrement with the same nesting. A column field wrapping from zero to all ones decrements the bank, and a bank wrap decrements the row.
- R7: Accepting the end address makes `done` 1 and `addr_valid` 0 on the next cycle.
- R8: If the start address is already at or past the end for the chosen direction, exactly one address is issued. The order used is row, then bank, then column field.
- R9: With `advance` low, the outputs hold the same address and `addr_valid` stays 1.
- R10: Bit 15 of the start and end words has no effect on the sequence.
- R11: A start pulse during a pass reloads all counters from the new start word.
- R12: `burst8_sel` holds the `burst8` value captured at the last start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that loads a pass |
| burst8 | input | 1 | Burst length at start: 1 = 8 beats, 0 = 4 beats |
| descend | input | 1 | Direction at start: 1 = down, 0 = up |
| start_cfg | input | 32 | Start address word |
| end_cfg | input | 32 | End address word |
| advance | input | 1 | Command engine accepts the current address |
| addr_valid | output | 1 | An address is offered |
| row_addr | output | 16 | Row address |
| col_addr | output | 16 | Column address, bit 10 low |
| bank_addr | output | 3 | Bank address |
| burst8_sel | output | 1 | Captured burst-length select |
| done | output | 1 | End address accepted |

## Verification
The hardest states to reach are the carries: the column skipping over bit 10, the column field wrapping into the bank, and the bank wrapping into the row, in both directions. Reaching them from reset would take thousands of accepts. The vector table instead places the start words a few steps before each boundary, so every carry is crossed within a handful of cycles. The stall, restart-during-pass and start-past-end cases are driven as directed sequences.

// File: rtl/mtest_addr_seq.sv
module mtest_addr_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        burst8,
  input  logic        descend,
  input  logic [31:0] start_cfg,
  input  logic [31:0] end_cfg,
  input  logic        advance,
  output logic        addr_valid,
  output logic [15:0] row_addr,
  output logic [15:0] col_addr,
  output logic [2:0]  bank_addr,
  output logic        burst8_sel,
  output logic        done
);
  localparam int ROW_W  = 16;
  localparam int COL_W  = 12;
  localparam int BANK_W = 3;
  localparam int IDX_W  = ROW_W + BANK_W + COL_W;

  logic [ROW_W-1:0]  row_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  cf_q;
  logic [IDX_W-1:0]  end_idx;
  logic desc_q, b8_q, busy_q, done_q;

  wire [IDX_W-1:0] cur_idx = {row_q, bank_q, cf_q};
  wire last      = desc_q ? (cur_idx <= end_idx) : (cur_idx >= end_idx);
  wire accept    = busy_q && advance;
  wire col_wrap  = desc_q ? (cf_q == '0)   : (&cf_q);
  wire bank_wrap = desc_q ? (bank_q == '0) : (&bank_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0; bank_q <= '0; cf_q <= '0; end_idx <= '0;
      desc_q <= 1'b0; b8_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else if (start) begin
      row_q   <= start_cfg[31:16];
      cf_q    <= start_cfg[14:3];
      bank_q  <= start_cfg[2:0];
      end_idx <= {end_cfg[31:16], end_cfg[2:0], end_cfg[14:3]};
      desc_q  <= descend;
      b8_q    <= burst8;
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
    end else if (accept) begin
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cf_q <= desc_q ? cf_q - 1'b1 : cf_q + 1'b1;
        if (col_wrap)
          bank_q <= desc_q ? bank_q - 1'b1 : bank_q + 1'b1;
        if (col_wrap && bank_wrap)
          row_q <= desc_q ? row_q - 1'b1 : row_q + 1'b1;
      end
    end
  end

  assign addr_valid = busy_q;
  assign done       = done_q;
  assign row_addr   = row_q;
  assign bank_addr  = bank_q;
  assign burst8_sel = b8_q;
  assign col_addr   = b8_q ? {cf_q[11:7], 1'b0, cf_q[6:0], 3'b000}
                           : {1'b0, cf_q[11:8], 1'b0, cf_q[7:0], 2'b00};

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> addr_valid && !done && row_addr == $past(start_cfg[31:16])
              && bank_addr == $past(start_cfg[2:0]));

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !advance && !start) |=> addr_valid && $stable(row_addr)
              && $stable(col_addr) && $stable(bank_addr));

  a_r7_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && advance && !start && last) |=> done && !addr_valid);

  a_r7_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid);

  a_r3_no_wrap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && advance && !start && !last && !col_wrap) |=>
      $stable(row_addr) && $stable(bank_addr) && !$stable(col_addr));
endmodule

// File: tb/mtest_addr_seq_bench.sv
module mtest_addr_seq_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, burst8 = 1'b0, descend = 1'b0;
  logic advance = 1'b0;
  logic [31:0] start_cfg = '0, end_cfg = '0;
  logic addr_valid, burst8_sel, done;
  logic [15:0] row_addr, col_addr;
  logic [2:0] bank_addr;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtest_addr_seq u_mtest_addr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .burst8(burst8), .descend(descend),
    .start_cfg(start_cfg), .end_cfg(end_cfg), .advance(advance),
    .addr_valid(addr_valid), .row_addr(row_addr), .col_addr(col_addr),
    .bank_addr(bank_addr), .burst8_sel(burst8_sel), .done(done));

  function automatic logic [31:0] word(input logic [15:0] r, input logic rsv,
                                       input logic [11:0] c, input logic [2:0] b);
    return {r, rsv, c, b};
  endfunction

  function automatic logic [15:0] expand(input logic [11:0] c, input logic b8);
    return b8 ? {c[11:7], 1'b0, c[6:0], 3'b000} : {1'b0, c[11:8], 1'b0, c[7:0], 2'b00};
  endfunction

  localparam logic [31:0] V_START [NV] = '{
    {16'd5, 1'b1, 12'h0FE, 3'd2}, {16'd1, 1'b0, 12'hFFE, 3'd7},
    {16'd3, 1'b0, 12'h001, 3'd0}, {16'd9, 1'b0, 12'h000, 3'd0},
    {16'd1, 1'b0, 12'h000, 3'd0}, {16'h1234, 1'b1, 12'h0AB, 3'd4}};
  localparam logic [31:0] V_END [NV] = '{
    {16'd5, 1'b0, 12'h102, 3'd2}, {16'd2, 1'b1, 12'h001, 3'd0},
    {16'd2, 1'b0, 12'hFFE, 3'd7}, {16'd8, 1'b0, 12'h000, 3'd0},
    {16'd2, 1'b0, 12'h000, 3'd0}, {16'h1234, 1'b0, 12'h0AB, 3'd4}};
  localparam logic [NV-1:0] V_B8   = 6'b000010;
  localparam logic [NV-1:0] V_DESC = 6'b010100;
  localparam int V_COUNT [NV] = '{5, 4, 4, 1, 1, 1};

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [31:0] s, input logic [31:0] e, input logic b8,
                          input logic d);
    @(negedge clk);
    start = 1'b1; start_cfg = s; end_cfg = e; burst8 = b8; descend = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [30:0] m;
    int cnt;
    repeat (3) @(negedge clk);
    check(!addr_valid && !done, "R1 in reset", {addr_valid, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!addr_valid && !done, "R1 after reset", {addr_valid, done}, 0);

    // R3 R4 R5 R6 R8 R10 R12 through the vector table
    for (int v = 0; v < NV; v++) begin
      advance = 1'b1;
      do_start(V_START[v], V_END[v], V_B8[v], V_DESC[v]);
      m = {V_START[v][31:16], V_START[v][2:0], V_START[v][14:3]};
      cnt = 0;
      while (!done && cnt < 64) begin
        if (addr_valid) begin
          check(row_addr == m[30:15], "R2/R5/R6 row", row_addr, m[30:15]);
          check(bank_addr == m[14:12], "R5/R6 bank", bank_addr, m[14:12]);
          check(col_addr == expand(m[11:0], V_B8[v]), "R3/R4 column", col_addr,
                expand(m[11:0], V_B8[v]));
          check(burst8_sel == V_B8[v], "R12 burst select", burst8_sel, V_B8[v]);
          cnt++;
          m = V_DESC[v] ? m - 1'b1 : m + 1'b1;
        end
        @(negedge clk);
      end
      check(cnt == V_COUNT[v], "R8/R10 access count", cnt, V_COUNT[v]);
      check(done && !addr_valid, "R7 done after end", {done, addr_valid}, 2'b10);
    end

    // R9 stall with advance low, then one step of +4
    advance = 1'b0;
    do_start(word(16'd7, 1'b0, 12'h010, 3'd1), word(16'd7, 1'b0, 12'h020, 3'd1), 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      check(addr_valid && col_addr == 16'h0040 && row_addr == 16'd7 && bank_addr == 3'd1,
            "R9 stall hold", col_addr, 16'h0040);
      @(negedge clk);
    end
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check(col_addr == 16'h0044, "R3 step of 4", col_addr, 16'h0044);
    check(!done && addr_valid, "R9 still active", {done, addr_valid}, 2'b01);

    // R11 restart during a pass
    do_start(word(16'hABCD, 1'b0, 12'h007, 3'd5), word(16'hABCD, 1'b0, 12'h100, 3'd5), 1'b1, 1'b0);
    check(row_addr == 16'hABCD && bank_addr == 3'd5, "R11 reload row/bank",
          {row_addr, bank_addr}, {16'hABCD, 3'd5});
    check(col_addr == expand(12'h007, 1'b1), "R11 reload column", col_addr,
          expand(12'h007, 1'b1));
    check(burst8_sel && !done, "R12 select after restart", {burst8_sel, done}, 2'b10);
    advance = 1'b1;
    @(negedge clk);
    check(col_addr == expand(12'h007, 1'b1) + 16'd8, "R3 step of 8", col_addr,
          expand(12'h007, 1'b1) + 16'd8);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule